// File: doc/BRIEF.md
# BCD Clock and Calendar Counter Chain

This block is the timekeeping counter chain of a real-time clock. A single-cycle `tick` enable, normally pulsed once per second by a 2^15 divider fed from a 32.768 kHz crystal clock, advances a chain of BCD digits. The chain holds seconds, minutes, hours, weekday, day of month, month and a two-digit year. Each digit rolls over at its own limit and carries into the next digit.

Hours run in either a 24-hour or a 12-hour mode with an AM/PM flag. Both the mode bit and the flag sit in the spare upper bits of the hours-tens digit. February's length comes from a two-bit leap phase kept in the spare upper bits of the day-tens digit. A host loads any single digit through one write port. All thirteen digits are always visible on a flat output vector, so software reads a digit by selecting the matching nibble.

Top module: `rtc_calendar_chain`

## Requirements
- R1: Digit k of `digits` occupies bits [4k+3:4k], with k = 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens, 6 weekday, 7 day units, 8 day tens, 9 month units, 10 month tens, 11 year units, 12 year tens. After reset the digits read 00:00:00, 24-hour mode, AM, weekday 0, day 01, month 01, year 00, leap phase 0.
- R2: On each cycle with `tick` high, seconds advance as BCD 00..59. 59 wraps to 00 and advances minutes, which count 00..59 the same way and carry into hours.
- R3: With bit 3 of the hours-tens digit set (24-hour mode), hours count 00..23, and 23 to 00 advances the day.
- R4: With bit 3 of the hours-tens digit clear (12-hour mode), hours run 12, 01, ..., 11. The step from 11 to 12 toggles the PM flag (bit 2 of hours-tens, 1 = PM), and the step from 11 PM to 12 AM advances the day.
- R5: A write to the hours-tens digit with data bit 3 set stores bit 2 as 0.
- R6: Each day advance steps the weekday 0..6, with 6 wrapping to 0.
- R7: Days count from 01. Months 04, 06, 09 and 11 have 30 days, and the other months except 02 have 31. After the last day the day returns to 01 and the month advances, with 12 wrapping to 01 and advancing the year.
- R8: February has 29 days when (10 × year tens + year units + L) mod 4 is 0, where L is bits 3:2 of the day-tens digit, and 28 days otherwise.
- R9: The year counts 00..99, and 99 wraps to 00.
- R10: With `wr_en` high, `wr_sel` 0..12 picks digit k and loads it from `wr_data`. Seconds tens, minutes tens and weekday keep bits 2:0, month tens keeps bit 0, day tens and hours tens keep all four bits, and the other digits keep all four bits. The write wins over a same-cycle increment of that digit, while carries out of the old value still advance the other digits.
- R11: A write with `wr_sel` 13, 14 or 15 changes no digit.
- R12: With neither `tick` nor `wr_en` high, all digits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle advance enable (1 Hz in use) |
| wr_en | input | 1 | Host digit write strobe |
| wr_sel | input | 4 | Digit index for the write |
| wr_data | input | 4 | Write data nibble |
| digits | output | 52 | All thirteen digits, digit k at bits [4k+3:4k] |

## Verification
Month ends, February in each leap phase, and the December-to-January year carry are the hard cases. From reset they sit months of ticks away. The bench reaches them by loading year, month, day 27 and the leap phase directly for every month, for twelve years and all four phases. Before each tick sequence it reloads the time to 23:59:58, so every day boundary through the month end is crossed in a few cycles and compared against an arithmetic calendar model. A 12-hour pass walks every hour over a full AM/PM day the same way.

// File: rtl/rtc_calendar_chain.sv
module rtc_calendar_chain (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [3:0]  wr_data,
  output logic [51:0] digits
);

  logic [3:0] s1, mi1, h1, d1, mo1, y1, y10;
  logic [2:0] s10, mi10, w;
  logic [1:0] h10, d10, leap;
  logic       mode24, pm, mo10;

  logic       en_mi, en_h, en_day, en_mo, en_yr;
  logic       h_is23, h_is11, h_is12;
  logic [1:0] yr_phase;
  logic [4:0] mon_v, last_day;
  logic [5:0] day_v;

  assign en_mi  = tick && s1 == 4'd9 && s10 == 3'd5;
  assign en_h   = en_mi && mi1 == 4'd9 && mi10 == 3'd5;
  assign h_is23 = h10 == 2'd2 && h1 == 4'd3;
  assign h_is11 = h10 == 2'd1 && h1 == 4'd1;
  assign h_is12 = h10 == 2'd1 && h1 == 4'd2;
  assign en_day = en_h && (mode24 ? h_is23 : (h_is11 && pm));

  assign yr_phase = {y10[0], 1'b0} + y1[1:0] + leap;
  assign mon_v    = mo10 ? 5'd10 + {1'b0, mo1} : {1'b0, mo1};
  assign day_v    = 6'(d10) * 6'd10 + {2'b00, d1};

  always_comb begin
    case (mon_v)
      5'd2:                        last_day = (yr_phase == 2'd0) ? 5'd29 : 5'd28;
      5'd4, 5'd6, 5'd9, 5'd11:     last_day = 5'd30;
      default:                     last_day = 5'd31;
    endcase
  end

  assign en_mo = en_day && day_v == {1'b0, last_day};
  assign en_yr = en_mo && mo10 && mo1 == 4'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s10 <= '0; mi1 <= '0; mi10 <= '0;
      h1 <= '0; h10 <= '0; mode24 <= 1'b1; pm <= 1'b0;
      w <= '0; d1 <= 4'd1; d10 <= '0; leap <= '0;
      mo1 <= 4'd1; mo10 <= 1'b0; y1 <= '0; y10 <= '0;
    end else begin
      if (tick) begin
        s1 <= (s1 == 4'd9) ? 4'd0 : s1 + 4'd1;
        if (s1 == 4'd9) s10 <= (s10 == 3'd5) ? 3'd0 : s10 + 3'd1;
      end
      if (en_mi) begin
        mi1 <= (mi1 == 4'd9) ? 4'd0 : mi1 + 4'd1;
        if (mi1 == 4'd9) mi10 <= (mi10 == 3'd5) ? 3'd0 : mi10 + 3'd1;
      end
      if (en_h) begin
        if (mode24) begin
          if (h_is23) begin h10 <= 2'd0; h1 <= 4'd0; end
          else if (h1 == 4'd9) begin h10 <= h10 + 2'd1; h1 <= 4'd0; end
          else h1 <= h1 + 4'd1;
        end else begin
          if (h_is12) begin h10 <= 2'd0; h1 <= 4'd1; end
          else if (h_is11) begin h1 <= 4'd2; pm <= ~pm; end
          else if (h1 == 4'd9) begin h10 <= 2'd1; h1 <= 4'd0; end
          else h1 <= h1 + 4'd1;
        end
      end
      if (en_day) begin
        w <= (w == 3'd6) ? 3'd0 : w + 3'd1;
        if (en_mo) begin d10 <= 2'd0; d1 <= 4'd1; end
        else if (d1 == 4'd9) begin d10 <= d10 + 2'd1; d1 <= 4'd0; end
        else d1 <= d1 + 4'd1;
      end
      if (en_mo) begin
        if (en_yr) begin mo10 <= 1'b0; mo1 <= 4'd1; end
        else if (mo1 == 4'd9) begin mo10 <= 1'b1; mo1 <= 4'd0; end
        else mo1 <= mo1 + 4'd1;
      end
      if (en_yr) begin
        y1 <= (y1 == 4'd9) ? 4'd0 : y1 + 4'd1;
        if (y1 == 4'd9) y10 <= (y10 == 4'd9) ? 4'd0 : y10 + 4'd1;
      end
      if (wr_en) begin
        case (wr_sel)
          4'd0:  s1   <= wr_data;
          4'd1:  s10  <= wr_data[2:0];
          4'd2:  mi1  <= wr_data;
          4'd3:  mi10 <= wr_data[2:0];
          4'd4:  h1   <= wr_data;
          4'd5:  begin mode24 <= wr_data[3]; pm <= wr_data[2] & ~wr_data[3]; h10 <= wr_data[1:0]; end
          4'd6:  w    <= wr_data[2:0];
          4'd7:  d1   <= wr_data;
          4'd8:  begin leap <= wr_data[3:2]; d10 <= wr_data[1:0]; end
          4'd9:  mo1  <= wr_data;
          4'd10: mo10 <= wr_data[0];
          4'd11: y1   <= wr_data;
          4'd12: y10  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign digits = {y10, y1, 3'b000, mo10, mo1, leap, d10, d1, 1'b0, w,
                   mode24, pm, h10, h1, 1'b0, mi10, mi1, 1'b0, s10, s1};

endmodule

// File: rtl/rtc_calendar_chain_chk.sv
module rtc_calendar_chain_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        wr_en,
  input logic [3:0]  wr_sel,
  input logic [3:0]  wr_data,
  input logic [51:0] digits
);

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en && digits[3:0] == 4'd9 && digits[7:4] == 4'd5 |=> digits[7:0] == 8'h00);

  a_r5_mode_clears_pm: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 4'd5 && wr_data[3] |=> digits[23:22] == 2'b10);

  a_r10_sec_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 4'd0 |=> digits[3:0] == $past(wr_data));

  a_r11_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel >= 4'd13 && !tick |=> $stable(digits));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_en |=> $stable(digits));

endmodule

bind rtc_calendar_chain rtc_calendar_chain_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .digits(digits)
);

// File: tb/rtc_calendar_chain_test.sv
module rtc_calendar_chain_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [3:0]  wr_data = '0;
  logic [51:0] digits;

  int checks = 0;
  int fails = 0;

  int sec, mn, hr, m24, pm, dow, day, mon, yr, lp;

  rtc_calendar_chain uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .digits(digits)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int mdays(int m, int y, int l);
    if (m == 2) return ((y + l) % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [51:0] expd();
    return {4'(yr / 10), 4'(yr % 10), 4'(mon / 10), 4'(mon % 10),
            2'(lp), 2'(day / 10), 4'(day % 10), 4'(dow),
            1'(m24), 1'(pm), 2'(hr / 10), 4'(hr % 10),
            4'(mn / 10), 4'(mn % 10), 4'(sec / 10), 4'(sec % 10)};
  endfunction

  task automatic m_reset();
    sec = 0; mn = 0; hr = 0; m24 = 1; pm = 0;
    dow = 0; day = 1; mon = 1; yr = 0; lp = 0;
  endtask

  task automatic m_step();
    bit dayc = 0;
    sec++;
    if (sec == 60) begin
      sec = 0; mn++;
      if (mn == 60) begin
        mn = 0;
        if (m24 != 0) begin
          hr++;
          if (hr == 24) begin hr = 0; dayc = 1; end
        end else if (hr == 12) hr = 1;
        else if (hr == 11) begin hr = 12; if (pm != 0) dayc = 1; pm = 1 - pm; end
        else hr++;
      end
    end
    if (dayc) begin
      dow = (dow + 1) % 7;
      day++;
      if (day > mdays(mon, yr, lp)) begin
        day = 1; mon++;
        if (mon == 13) begin mon = 1; yr = (yr + 1) % 100; end
      end
    end
  endtask

  task automatic m_write(logic [3:0] s, logic [3:0] d);
    int v = int'(d);
    case (s)
      4'd0:  sec = (sec / 10) * 10 + v;
      4'd1:  sec = (v & 7) * 10 + sec % 10;
      4'd2:  mn  = (mn / 10) * 10 + v;
      4'd3:  mn  = (v & 7) * 10 + mn % 10;
      4'd4:  hr  = (hr / 10) * 10 + v;
      4'd5:  begin m24 = (v >> 3) & 1; pm = (m24 != 0) ? 0 : (v >> 2) & 1; hr = (v & 3) * 10 + hr % 10; end
      4'd6:  dow = v & 7;
      4'd7:  day = (day / 10) * 10 + v;
      4'd8:  begin lp = (v >> 2) & 3; day = (v & 3) * 10 + day % 10; end
      4'd9:  mon = (mon / 10) * 10 + v;
      4'd10: mon = (v & 1) * 10 + mon % 10;
      4'd11: yr  = (yr / 10) * 10 + v;
      4'd12: yr  = v * 10 + yr % 10;
      default: ;
    endcase
  endtask

  task automatic check(string tag);
    checks++;
    if (digits !== expd()) begin
      fails++;
      $display("FAIL %s: digits actual %h expected %h", tag, digits, expd());
    end
  endtask

  task automatic cyc(bit t, bit we, logic [3:0] s, logic [3:0] d, string tag);
    tick = t; wr_en = we; wr_sel = s; wr_data = d;
    @(posedge clk);
    if (t) m_step();
    if (we) m_write(s, d);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check(tag);
  endtask

  task automatic wr(int s, int d, string tag);
    cyc(1'b0, 1'b1, 4'(s), 4'(d), tag);
  endtask

  task automatic set_late_24(string tag);
    wr(0, 8, tag); wr(1, 5, tag); wr(2, 9, tag); wr(3, 5, tag);
    wr(4, 3, tag); wr(5, 4'b1010, tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state");

    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 4'd0, 4'd0, "R12 idle hold");

    for (int i = 0; i < 130; i++) cyc(1'b1, 1'b0, 4'd0, 4'd0, "R2 seconds/minutes count");

    for (int i = 13; i < 16; i++) cyc(1'b0, 1'b1, 4'(i), 4'hF, "R11 unused select");

    wr(5, 4'b1110, "R5 24h write clears PM");
    wr(5, 4'b1010, "R5 24h write clears PM");

    wr(0, 9, "R10 setup"); wr(1, 5, "R10 setup");
    cyc(1'b1, 1'b1, 4'd0, 4'd4, "R10 write beats increment");
    wr(2, 9, "R10 setup"); wr(3, 5, "R10 setup"); wr(0, 9, "R10 setup"); wr(1, 5, "R10 setup");
    cyc(1'b1, 1'b1, 4'd3, 4'd2, "R10 write beats carry");

    for (int l = 0; l < 4; l++) begin
      for (int yi = 0; yi < 12; yi++) begin
        for (int m = 1; m <= 12; m++) begin
          int y = (yi < 8) ? yi : 88 + yi;
          wr(11, y % 10, "R10 load year units");
          wr(12, y / 10, "R10 load year tens");
          wr(9, m % 10, "R10 load month units");
          wr(10, m / 10, "R10 load month tens");
          wr(7, 7, "R10 load day units");
          wr(8, (l << 2) | 2, "R10 load day tens and leap");
          for (int dd = 0; dd < 5; dd++) begin
            set_late_24("R3 set 23:59:58");
            for (int k = 0; k < 3; k++)
              cyc(1'b1, 1'b0, 4'd0, 4'd0, "R3 R6 R7 R8 R9 calendar rollover");
          end
        end
      end
    end

    wr(4, 1, "R4 load 11 AM");
    wr(5, 4'b0001, "R4 load 11 AM");
    for (int i = 0; i < 26; i++) begin
      wr(0, 9, "R4 set xx:59:59"); wr(1, 5, "R4 set xx:59:59");
      wr(2, 9, "R4 set xx:59:59"); wr(3, 5, "R4 set xx:59:59");
      cyc(1'b1, 1'b0, 4'd0, 4'd0, "R4 twelve-hour step");
    end

    wr(5, 4'b0111, "R5 12h write keeps PM");
    wr(5, 4'b1101, "R5 24h write clears PM");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule